// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Host Port

This block moves bytes between time-division streams. There are eight receive streams and eight transmit streams. Each frame has 32 slots, and in every clock cycle each stream carries one channel byte. Incoming bytes are captured into a data store that has two banks, selected by frame parity. While one frame is being captured, the previous complete frame is available to be read.

For every transmit stream and slot, a 16-bit connection word decides what goes out: either a byte fetched from the captured frame at a chosen stream and channel, or a constant byte held in the word itself. The same word carries a driver enable for that channel, a loopback flag that feeds the transmitted byte back into the capture path, and a stored-only delay-mode flag. A global enable (a pin OR'd with a control bit) gates every driver.

A byte-wide host port reaches a control register at address zero. When address bit 7 is set, it reaches a 32-byte window onto one stream, chosen by the control register. Through that window the host can read and write either half of the connection words, or read (but not write) the captured data.

Top module: `tsi_switch`

## Requirements
- R1: With rst_n low at a clock edge, the block clears the control register, the connection words, the data banks and the slot counter. After reset, tx_en and tx_data are zero, host_rdata is zero and frame_mark is low.
- R2: The slot counter walks 0..31 and then wraps, toggling the frame parity. The outputs for a slot appear in the cycle after the edge that consumed that slot's rx_data, and frame_mark is high exactly when those outputs belong to slot 0.
- R3: Connection word bit 8 is the constant-byte select. When it is 0, transmit stream s in slot c sends the byte that was received in the previous frame on stream word[7:5], channel word[4:0].
- R4: When connection word bit 8 is 1, transmit stream s in that slot sends word[7:0] unchanged.
- R5: tx_en[s] is the AND of the global enable (out_en_pin OR control bit 5) and connection word bit 9. When tx_en[s] is 0, its tx_data byte is zero. With the global enable low, all tx_en bits are zero whatever the connection words hold.
- R6: When connection word bit 10 of stream s, slot c is 1, the byte captured for receive stream s, channel c is the byte chosen for transmit stream s, slot c (before enable gating), and the rx_data byte is not used.
- R7: Address 0x00 is the control register. It is fully readable and writable: bits 2:0 pick the window stream, bit 3 picks the window target (0 connection words, 1 captured data), bit 4 picks the connection-word half (0 bits 7:0, 1 bits 15:8), and bit 5 is the standby enable. A read issued at an edge returns its byte on host_rdata after that edge, and host_rdata holds between reads.
- R8: With address bit 7 set and control bit 3 clear, address bits 4:0 select the channel of the window stream. A write replaces the selected half of that connection word and a read returns it. Address bits 6:5 are ignored, and word bits 15:11 (the delay-mode flag at bit 11 and the spare bits) are stored and read back only.
- R9: With address bit 7 set and control bit 3 set, a read returns the captured byte of the window stream and channel from the bank not being written in that cycle. Writes there change nothing.
- R10: Addresses with bit 7 clear, other than 0x00, read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| out_en_pin | input | 1 | Global driver enable, OR'd with control bit 5 |
| rx_data | input | 64 | Receive bytes, stream s on bits 8s+7:8s |
| tx_data | output | 64 | Transmit bytes, stream s on bits 8s+7:8s, zero when disabled |
| tx_en | output | 8 | Per-stream driver enable for the current slot |
| frame_mark | output | 1 | High while the outputs belong to slot 0 |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 8 | Host address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |

## Verification
The hardest case to reach from the ports is a byte that was captured through loopback and is later read back or switched to another output. It only shows up a frame after the slot in which it was made, and only through the bank that is not being written. The bench programs all 256 connection words so that constant-byte, disabled and loopback channels are interleaved with switched ones. It then runs several frames with a changing receive pattern and reads back every captured byte through the data window. A reference model in the bench tracks both banks and flags which bytes came through loopback, so those reads are checked against that requirement.

// File: rtl/tsi_pkg.sv
// Shared constants for the time-slot interchange switch.
// Assumes stream and channel counts are powers of two whose index widths
// together fit in the low byte of a connection word.
package tsi_pkg;
    localparam int CW_WIDTH   = 16;
    localparam int CW_CONST   = 8;   // constant-byte select
    localparam int CW_OE      = 9;   // per-channel driver enable
    localparam int CW_LOOP    = 10;  // loopback into capture path
    localparam int CTL_TARGET = 3;   // window: 0 connection, 1 data
    localparam int CTL_HALF   = 4;   // connection half: 0 low, 1 high
    localparam int CTL_STBY   = 5;   // standby (global) enable
    typedef logic [CW_WIDTH-1:0] conn_word_t;
endpackage

// File: rtl/tsi_slot_timer.sv
// Slot and frame-parity counter. Counts one slot per clock and toggles the
// parity at each frame wrap. Assumes NUM_CHANNELS is a power of two.
module tsi_slot_timer #(
    parameter int NUM_CHANNELS = 32,
    localparam int CHW = $clog2(NUM_CHANNELS)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [CHW-1:0] slot,
    output logic           parity
);
    localparam logic [CHW-1:0] LAST = CHW'(NUM_CHANNELS - 1);

    // advance the slot, flip parity on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot   <= '0;
            parity <= 1'b0;
        end else if (slot == LAST) begin
            slot   <= '0;
            parity <= ~parity;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LAST) |=> (slot == '0 && parity != $past(parity)));
endmodule

// File: rtl/tsi_conn_mem.sv
// Connection word store: one 16-bit word per stream and slot. The host
// writes one byte half at a time. Every stream reads its word for the
// current slot in parallel. Cleared by reset.
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 8,
    parameter int NUM_CHANNELS = 32,
    localparam int SW  = $clog2(NUM_STREAMS),
    localparam int CHW = $clog2(NUM_CHANNELS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CHW-1:0]              slot,
    input  logic                        host_we,
    input  logic [SW-1:0]               host_str,
    input  logic [CHW-1:0]              host_chn,
    input  logic                        host_hi,
    input  logic [7:0]                  host_wbyte,
    output conn_word_t                  host_word,
    output conn_word_t [NUM_STREAMS-1:0] rd_word
);
    conn_word_t mem [NUM_STREAMS][NUM_CHANNELS];

    // reset clear and host byte-half writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STREAMS; s++)
                for (int c = 0; c < NUM_CHANNELS; c++)
                    mem[s][c] <= '0;
        end else if (host_we) begin
            if (host_hi) mem[host_str][host_chn][15:8] <= host_wbyte;
            else         mem[host_str][host_chn][7:0]  <= host_wbyte;
        end
    end

    // per-stream slot read ports
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_rd
        assign rd_word[s] = mem[s][slot];
    end

    // host read port
    assign host_word = mem[host_str][host_chn];
endmodule

// File: rtl/tsi_data_mem.sv
// Double-banked capture store. Each cycle, every stream writes its byte for
// the current slot into the bank given by frame parity. All reads come from
// the other bank, which holds the last complete frame. Cleared by reset.
module tsi_data_mem #(
    parameter int NUM_STREAMS  = 8,
    parameter int NUM_CHANNELS = 32,
    localparam int SW  = $clog2(NUM_STREAMS),
    localparam int CHW = $clog2(NUM_CHANNELS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CHW-1:0]                    slot,
    input  logic                              wr_bank,
    input  logic [NUM_STREAMS-1:0][7:0]       wr_bytes,
    input  logic [NUM_STREAMS-1:0][SW-1:0]    rd_str,
    input  logic [NUM_STREAMS-1:0][CHW-1:0]   rd_chn,
    output logic [NUM_STREAMS-1:0][7:0]       rd_bytes,
    input  logic [SW-1:0]                     host_str,
    input  logic [CHW-1:0]                    host_chn,
    output logic [7:0]                        host_byte
);
    logic [7:0] mem [2][NUM_STREAMS][NUM_CHANNELS];

    // capture the current slot of every stream into the write bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < NUM_STREAMS; s++)
                    for (int c = 0; c < NUM_CHANNELS; c++)
                        mem[b][s][c] <= '0;
        end else begin
            for (int s = 0; s < NUM_STREAMS; s++)
                mem[wr_bank][s][slot] <= wr_bytes[s];
        end
    end

    // switched reads from the completed bank
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_rd
        assign rd_bytes[s] = mem[~wr_bank][rd_str[s]][rd_chn[s]];
    end

    // host read from the completed bank
    assign host_byte = mem[~wr_bank][host_str][host_chn];
endmodule

// File: rtl/tsi_switch.sv
// Top level of the time-slot interchange switch. It selects a byte for each
// transmit stream and slot, gates the driver enables, loops transmitted
// bytes back into capture, and decodes the host port.
// Assumes power-of-two stream and channel counts, SW <= 3 and SW + CHW <= 8.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_STREAMS  = 8,
    parameter int NUM_CHANNELS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     out_en_pin,
    input  logic [NUM_STREAMS*8-1:0] rx_data,
    output logic [NUM_STREAMS*8-1:0] tx_data,
    output logic [NUM_STREAMS-1:0]   tx_en,
    output logic                     frame_mark,
    input  logic                     host_sel,
    input  logic                     host_we,
    input  logic [7:0]               host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata
);
    localparam int SW  = $clog2(NUM_STREAMS);
    localparam int CHW = $clog2(NUM_CHANNELS);

    logic [CHW-1:0]                    slot;
    logic                              parity;
    logic [7:0]                        ctrl;
    conn_word_t [NUM_STREAMS-1:0]      rd_word;
    conn_word_t                        host_word;
    logic [NUM_STREAMS-1:0][SW-1:0]    src_str;
    logic [NUM_STREAMS-1:0][CHW-1:0]   src_chn;
    logic [NUM_STREAMS-1:0][7:0]       dm_bytes, sel_bytes, cap_bytes;
    logic [NUM_STREAMS-1:0]            ch_en;
    logic [7:0]                        dm_host_byte;
    logic                              glob_en, is_ctrl, is_win, rd_req, cm_we;
    logic [SW-1:0]                     win_str;
    logic [CHW-1:0]                    win_chn;
    logic [NUM_STREAMS*5-1:0]          unused_word_bits;

    tsi_slot_timer #(.NUM_CHANNELS(NUM_CHANNELS)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot(slot), .parity(parity));

    // host address decode
    assign is_ctrl = (host_addr == 8'h00);
    assign is_win  = host_addr[7];
    assign win_str = ctrl[SW-1:0];
    assign win_chn = host_addr[CHW-1:0];
    assign rd_req  = host_sel && !host_we;
    assign cm_we   = host_sel && host_we && is_win && !ctrl[CTL_TARGET];
    assign glob_en = out_en_pin | ctrl[CTL_STBY];

    tsi_conn_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_conn (
        .clk(clk), .rst_n(rst_n), .slot(slot),
        .host_we(cm_we), .host_str(win_str), .host_chn(win_chn),
        .host_hi(ctrl[CTL_HALF]), .host_wbyte(host_wdata),
        .host_word(host_word), .rd_word(rd_word));

    // per-stream source selection and capture value
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_sel
        assign src_str[s]   = rd_word[s][CHW +: SW];
        assign src_chn[s]   = rd_word[s][CHW-1:0];
        assign sel_bytes[s] = rd_word[s][CW_CONST] ? rd_word[s][7:0] : dm_bytes[s];
        assign cap_bytes[s] = rd_word[s][CW_LOOP] ? sel_bytes[s] : rx_data[s*8 +: 8];
        assign ch_en[s]     = glob_en & rd_word[s][CW_OE];
        assign unused_word_bits[s*5 +: 5] = rd_word[s][15:11];
    end

    tsi_data_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_data (
        .clk(clk), .rst_n(rst_n), .slot(slot), .wr_bank(parity),
        .wr_bytes(cap_bytes), .rd_str(src_str), .rd_chn(src_chn),
        .rd_bytes(dm_bytes), .host_str(win_str), .host_chn(win_chn),
        .host_byte(dm_host_byte));

    // register the transmit bytes, enables and slot-0 marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data    <= '0;
            tx_en      <= '0;
            frame_mark <= 1'b0;
        end else begin
            for (int s = 0; s < NUM_STREAMS; s++)
                tx_data[s*8 +: 8] <= ch_en[s] ? sel_bytes[s] : 8'h00;
            tx_en      <= ch_en;
            frame_mark <= (slot == '0);
        end
    end

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl <= '0;
        else if (host_sel && host_we && is_ctrl) ctrl <= host_wdata;
    end

    // registered host read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (rd_req) begin
            if (is_ctrl)                  host_rdata <= ctrl;
            else if (!is_win)             host_rdata <= 8'h00;
            else if (ctrl[CTL_TARGET])    host_rdata <= dm_host_byte;
            else if (ctrl[CTL_HALF])      host_rdata <= host_word[15:8];
            else                          host_rdata <= host_word[7:0];
        end
    end

    // R5
    glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(glob_en) |-> (tx_en == '0));

    // R2
    frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> ($past(slot) == '0));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> $stable(host_rdata));
endmodule

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 32;

    logic clk = 0, rst_n = 0, out_en_pin = 0;
    logic [NS*8-1:0] rx_data = '0;
    logic [NS*8-1:0] tx_data;
    logic [NS-1:0]   tx_en;
    logic            frame_mark;
    logic host_sel = 0, host_we = 0;
    logic [7:0] host_addr = 0, host_wdata = 0, host_rdata;

    int checks = 0, errors = 0, cyc = 0;
    bit chk_on = 0, done = 0;

    // reference state
    logic [15:0] m_cm [NS][NC];
    logic [7:0]  m_dm [2][NS][NC];
    bit          m_lbf [2][NS][NC];
    logic [7:0]  m_ctrl;
    int          m_slot;
    bit          m_par;
    logic [7:0]  exp_tx [NS];
    bit          exp_en [NS];
    string       exp_req [NS];
    bit          exp_fm, rd_chk;
    logic [7:0]  exp_rd;
    string       rd_req;

    tsi_switch dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // reference model stepped at every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                for (int c = 0; c < NC; c++) begin
                    m_cm[s][c] = '0;
                    for (int b = 0; b < 2; b++) begin m_dm[b][s][c] = '0; m_lbf[b][s][c] = 0; end
                end
                exp_tx[s] = '0; exp_en[s] = 0; exp_req[s] = "R1";
            end
            m_ctrl = '0; m_slot = 0; m_par = 0; exp_fm = 0; rd_chk = 0; exp_rd = '0;
        end else begin
            automatic bit g = out_en_pin | m_ctrl[5];
            automatic logic [7:0] nb [NS];
            automatic bit nlb [NS];
            automatic int st = int'(m_ctrl[2:0]);
            automatic int ch = int'(host_addr[4:0]);
            for (int s = 0; s < NS; s++) begin
                automatic logic [15:0] w = m_cm[s][m_slot];
                automatic logic [7:0] b = w[8] ? w[7:0]
                                      : m_dm[!m_par][int'(w[7:5])][int'(w[4:0])];
                exp_en[s]  = g & w[9];
                exp_tx[s]  = exp_en[s] ? b : 8'h00;
                exp_req[s] = !exp_en[s] ? "R5" : (w[8] ? "R4" : "R3");
                nb[s]  = w[10] ? b : rx_data[s*8 +: 8];
                nlb[s] = w[10];
            end
            exp_fm = (m_slot == 0);
            rd_chk = host_sel && !host_we;
            if (rd_chk) begin
                if (host_addr == 8'h00) begin exp_rd = m_ctrl; rd_req = "R7"; end
                else if (!host_addr[7]) begin exp_rd = 8'h00; rd_req = "R10"; end
                else if (m_ctrl[3]) begin
                    exp_rd = m_dm[!m_par][st][ch];
                    rd_req = m_lbf[!m_par][st][ch] ? "R6" : "R9";
                end else begin
                    exp_rd = m_ctrl[4] ? m_cm[st][ch][15:8] : m_cm[st][ch][7:0];
                    rd_req = "R8";
                end
            end
            for (int s = 0; s < NS; s++) begin
                m_dm[m_par][s][m_slot] = nb[s];
                m_lbf[m_par][s][m_slot] = nlb[s];
            end
            if (host_sel && host_we) begin
                if (host_addr == 8'h00) m_ctrl = host_wdata;
                else if (host_addr[7] && !m_ctrl[3]) begin
                    if (m_ctrl[4]) m_cm[st][ch][15:8] = host_wdata;
                    else           m_cm[st][ch][7:0]  = host_wdata;
                end
            end
            if (m_slot == NC-1) begin m_slot = 0; m_par = !m_par; end
            else m_slot++;
        end
    end

    // compare outputs between edges
    always @(negedge clk) begin
        if (chk_on) begin
            for (int s = 0; s < NS; s++) begin
                check(exp_req[s], tx_data[s*8 +: 8], exp_tx[s], $sformatf("tx stream %0d", s));
                check("R5", {7'd0, tx_en[s]}, {7'd0, exp_en[s]}, $sformatf("tx_en stream %0d", s));
            end
            check("R2", {7'd0, frame_mark}, {7'd0, exp_fm}, "frame_mark");
            if (rd_chk) check(rd_req, host_rdata, exp_rd, "host read");
        end
    end

    // receive pattern changes every cycle
    initial forever begin
        @(negedge clk);
        cyc++;
        for (int s = 0; s < NS; s++) rx_data[s*8 +: 8] = 8'((cyc * 13 + s * 29 + 7) & 255);
    end

    task automatic hop(input logic we, input logic [7:0] a, input logic [7:0] d);
        host_sel = 1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    function automatic logic [7:0] low_byte(int s, int c);
        if (c % 7 == 3) return 8'((s * 32 + c) ^ 8'h5A);
        return {3'((s + 3) % 8), 5'(31 - c)};
    endfunction

    function automatic logic [7:0] high_byte(int s, int c);
        return {4'((s + c) & 15), c[0], (s == 2 && c % 4 == 1), ((s + c) % 5 != 0), (c % 7 == 3)};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset values before any active edge
        check("R1", tx_data[7:0] | tx_data[63:56], 8'h00, "tx_data after reset");
        check("R1", {tx_en}, 8'h00, "tx_en after reset");
        check("R1", host_rdata, 8'h00, "host_rdata after reset");
        check("R1", {7'd0, frame_mark}, 8'h00, "frame_mark after reset");
        chk_on = 1;
        hop(0, 8'h00, 0);                              // R7 ctrl reads zero
        // R8: program all connection words, some with address bits 6:5 set
        for (int s = 0; s < NS; s++) begin
            hop(1, 8'h00, 8'(s));
            for (int c = 0; c < NC; c++) hop(1, 8'(8'h80 | (c[0] ? 8'h60 : 8'h00) | c), low_byte(s, c));
            hop(1, 8'h00, 8'(s | 8'h10));
            for (int c = 0; c < NC; c++) hop(1, 8'(8'h80 | (c[1] ? 8'h20 : 8'h00) | c), high_byte(s, c));
        end
        // R8: read back both halves
        for (int s = 0; s < NS; s++)
            for (int h = 0; h < 2; h++) begin
                hop(1, 8'h00, 8'(s | (h << 4)));
                for (int c = 0; c < NC; c++) hop(0, 8'(8'h80 | c), 0);
            end
        hop(1, 8'h00, 8'h00);
        repeat (NC) @(negedge clk);                    // R5 global enable low
        out_en_pin = 1;
        repeat (3 * NC) @(negedge clk);                // R3 R4 R6 switching
        out_en_pin = 0;
        hop(1, 8'h00, 8'h20);                          // R5 standby bit enables
        repeat (NC + 5) @(negedge clk);
        // R9 / R6: read captured bytes of every stream
        for (int s = 0; s < NS; s++) begin
            hop(1, 8'h00, 8'(s | 8'h08));
            for (int c = 0; c < NC; c++) hop(0, 8'(8'h80 | c), 0);
        end
        // R9: writes to the data window are ignored
        hop(1, 8'h00, 8'h0A);
        for (int c = 0; c < 4; c++) hop(1, 8'(8'h80 | c), 8'hFF);
        for (int c = 0; c < 4; c++) hop(0, 8'(8'h80 | c), 0);
        // R10: non-window addresses
        hop(1, 8'h40, 8'h77);
        hop(0, 8'h40, 0);
        hop(0, 8'h13, 0);
        hop(0, 8'h00, 0);                              // R7 ctrl unchanged
        hop(1, 8'h00, 8'hC2);
        hop(0, 8'h00, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule